// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-programmed watchdog timer. It counts in two stages. A prescaler divides the core clock into a slower tick. Both countdown stages advance only on that tick. When the first stage runs out, the block raises a warning interrupt. This gives software a last chance to react. If software does not service the block, a second countdown (the grace period) starts. When the grace period ends, the block emits a reset pulse and disables itself.

Software programs both stage lengths and the enable bit in a single control word, and sets the tick rate in a separate divider register. It keeps the timer alive by writing 1 to the service register. Each service write reloads both live counts from the programmed lengths and restarts the tick phase. A read-only register shows both live counts at any time. The bus is a plain single-cycle write port with a combinational read port. It has four word registers, selected by a 2-bit word index.

Top module: `wdg_two_stage`

## Requirements
- R1: After reset, `warn_irq` and `sys_rst` are low, the control word (index 0) and the live-count word (index 2) read 0, and the divider (index 3) reads 1.
- R2: The control word holds the enable flag in bit 31, the first-stage length in bits [7:0] and the grace length in bits [15:8]. It reads back exactly those fields, and all other bits read 0.
- R3: The divider (index 3, bits [15:0]) sets the tick period to that many clock cycles. A value of 0 acts as 1. The divider reads back the written low 16 bits.
- R4: Writing the control word with bit 31 set loads both live counts from the written fields and restarts the tick phase. The first tick then falls at the D-th clock edge after the write edge, where D is the effective divider.
- R5: With first-stage length L1 (0 counts as 1) and effective divider D, `warn_irq` rises on the L1·D-th edge after the enabling or service write. It stays high until a service write, a disable, or the reset pulse.
- R6: With grace length L2 (0 counts as 1), `sys_rst` is high for exactly one clock cycle, starting at edge (L1+L2)·D. On that same edge `warn_irq` falls and bit 31 of the control word clears.
- R7: Writing index 1 with bit 0 set reloads both live counts from the programmed lengths, restarts the tick phase, clears `warn_irq` and returns the block to the first stage. A service write during the grace period therefore cancels the pending reset.
- R8: A write to index 1 with bit 0 clear has no effect on timing or outputs, and index 1 always reads 0.
- R9: While bit 31 is clear, both live counts hold and neither `warn_irq` nor `sys_rst` asserts.
- R10: The live-count word (index 2) shows the first-stage count in bits [7:0] and the grace count in bits [15:8]. Each count decrements by one per tick while its stage is active, and the first-stage count reads 0 during the grace period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word index: 0 control, 1 service, 2 live counts, 3 divider |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| warn_irq | output | 1 | Level warning interrupt after first-stage expiry |
| sys_rst | output | 1 | One-cycle reset pulse at grace expiry |

## Verification
The bench sweeps every combination of small stage lengths, including zero, and small divider values, including zero. For each one it computes the warning and reset edges arithmetically. A design that mishandles a zero length or a zero divider would stall, fire at once, or shift both events by a whole tick. A service write placed on the very edge where the grace stage would have ticked must win. Otherwise the reset pulse leaks out. A service write with bit 0 clear must leave the schedule untouched, and a mid-run disable must freeze the live counts. Both mistakes show up as moved events or changed counts at the ports.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_KICK = 2'd1;
  localparam logic [1:0] RG_LIVE = 2'd2;
  localparam logic [1:0] RG_DIV  = 2'd3;
  localparam int EN_POS = 31;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_ONE = 2'd1,
    ST_TWO = 2'd2
  } wdg_state_e;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             expire,
  input  logic [CNT_W-1:0] live1,
  input  logic [CNT_W-1:0] live2,
  output logic [31:0]      bus_rdata,
  output logic             en,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output logic             stop,
  output logic             reload,
  output logic [CNT_W-1:0] ld_f1,
  output logic [CNT_W-1:0] ld_f2
);
  localparam int F2_LO = CNT_W;
  localparam int F2_HI = 2 * CNT_W - 1;

  logic             en_q, en_d;
  logic [CNT_W-1:0] f1_q, f1_d, f2_q, f2_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_ctrl, wr_kick, wr_div;

  assign wr_ctrl = bus_wr && (bus_addr == RG_CTRL);
  assign wr_kick = bus_wr && (bus_addr == RG_KICK);
  assign wr_div  = bus_wr && (bus_addr == RG_DIV);

  assign start  = wr_ctrl && bus_wdata[EN_POS];
  assign stop   = wr_ctrl && !bus_wdata[EN_POS];
  assign reload = wr_kick && bus_wdata[0];

  // lengths used for a load: fresh fields on a control write, stored otherwise
  assign ld_f1 = start ? bus_wdata[CNT_W-1:0] : f1_q;
  assign ld_f2 = start ? bus_wdata[F2_HI:F2_LO] : f2_q;

  always_comb begin
    en_d  = en_q;
    f1_d  = f1_q;
    f2_d  = f2_q;
    div_d = div_q;
    if (wr_ctrl) begin
      en_d = bus_wdata[EN_POS];
      f1_d = bus_wdata[CNT_W-1:0];
      f2_d = bus_wdata[F2_HI:F2_LO];
    end else if (expire) begin
      en_d = 1'b0;
    end
    if (wr_div) div_d = bus_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      f1_q  <= '0;
      f2_q  <= '0;
      div_q <= DIV_W'(1);
    end else begin
      en_q  <= en_d;
      f1_q  <= f1_d;
      f2_q  <= f2_d;
      div_q <= div_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RG_CTRL: begin
        bus_rdata[EN_POS]      = en_q;
        bus_rdata[CNT_W-1:0]   = f1_q;
        bus_rdata[F2_HI:F2_LO] = f2_q;
      end
      RG_LIVE: begin
        bus_rdata[CNT_W-1:0]   = live1;
        bus_rdata[F2_HI:F2_LO] = live2;
      end
      RG_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      default: bus_rdata = '0;
    endcase
  end

  assign en  = en_q;
  assign div = div_q;
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  // zero divider behaves as one so the tick never stalls
  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign wrap = (cnt_q >= lim);
  assign tick = run && !restart && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (wrap)       cnt_d = '0;
    else                 cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdg_stages.sv
module wdg_stages
  import wdg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             reload,
  input  logic [CNT_W-1:0] ld_f1,
  input  logic [CNT_W-1:0] ld_f2,
  input  logic             tick,
  output logic [CNT_W-1:0] live1,
  output logic [CNT_W-1:0] live2,
  output logic             running,
  output logic             warn,
  output logic             rst_pulse,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  wdg_state_e       st_q, st_d;
  logic [CNT_W-1:0] c1_q, c1_d, c2_q, c2_d;
  logic             warn_q, warn_d, pulse_q, pulse_d;

  always_comb begin
    st_d    = st_q;
    c1_d    = c1_q;
    c2_d    = c2_q;
    warn_d  = warn_q;
    pulse_d = 1'b0;
    expire  = 1'b0;
    if (start) begin
      c1_d   = ld_f1;
      c2_d   = ld_f2;
      st_d   = ST_ONE;
      warn_d = 1'b0;
    end else if (stop) begin
      st_d   = ST_OFF;
      warn_d = 1'b0;
    end else if (reload) begin
      c1_d   = ld_f1;
      c2_d   = ld_f2;
      warn_d = 1'b0;
      if (st_q != ST_OFF) st_d = ST_ONE;
    end else if (tick) begin
      case (st_q)
        ST_ONE: begin
          if (c1_q <= ONE) begin
            c1_d   = '0;
            st_d   = ST_TWO;
            warn_d = 1'b1;
          end else begin
            c1_d = c1_q - ONE;
          end
        end
        ST_TWO: begin
          if (c2_q <= ONE) begin
            c2_d    = '0;
            st_d    = ST_OFF;
            warn_d  = 1'b0;
            pulse_d = 1'b1;
            expire  = 1'b1;
          end else begin
            c2_d = c2_q - ONE;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      c1_q    <= '0;
      c2_q    <= '0;
      warn_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      c1_q    <= c1_d;
      c2_q    <= c2_d;
      warn_q  <= warn_d;
      pulse_q <= pulse_d;
    end
  end

  assign live1     = c1_q;
  assign live2     = c2_q;
  assign running   = (st_q != ST_OFF);
  assign warn      = warn_q;
  assign rst_pulse = pulse_q;
endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        warn_irq,
  output logic        sys_rst
);
  logic             rst_q_n;
  logic             ctl_en, start, stop, reload, expire, running, tick;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] ld_f1, ld_f2, live1, live2;

  wdg_rst_sync u_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  wdg_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .expire    (expire),
    .live1     (live1),
    .live2     (live2),
    .bus_rdata (bus_rdata),
    .en        (ctl_en),
    .div       (div),
    .start     (start),
    .stop      (stop),
    .reload    (reload),
    .ld_f1     (ld_f1),
    .ld_f2     (ld_f2)
  );

  wdg_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .run     (running),
    .restart (start | reload),
    .div     (div),
    .tick    (tick)
  );

  wdg_stages #(.CNT_W(CNT_W)) u_stg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (start),
    .stop      (stop),
    .reload    (reload),
    .ld_f1     (ld_f1),
    .ld_f2     (ld_f2),
    .tick      (tick),
    .live1     (live1),
    .live2     (live2),
    .running   (running),
    .warn      (warn_irq),
    .rst_pulse (sys_rst),
    .expire    (expire)
  );
endmodule

// File: rtl/wdg_checks.sv
module wdg_checks #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             bus_wdata0,
  input logic             en,
  input logic             tick,
  input logic [2*CNT_W-1:0] live,
  input logic             warn,
  input logic             rst_pulse
);
  // R6: reset pulse lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  // R6: the reset pulse only follows a raised warning
  a_r6_after_warn: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(warn));

  // R5: warning only while the enable flag is set
  a_r5_warn_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> en);

  // R7: a service write clears the warning on the next cycle
  a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && bus_wdata0) |=> !warn);

  // R9: disabled and untouched means frozen counts and no reset
  a_r9_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_wr) |=> (!rst_pulse && $stable(live)));

  // R3: ticks only while enabled
  a_r3_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);
endmodule

bind wdg_two_stage wdg_checks #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata0 (bus_wdata[0]),
  .en         (ctl_en),
  .tick       (tick),
  .live       ({live2, live1}),
  .warn       (warn_irq),
  .rst_pulse  (sys_rst)
);

// File: tb/sim_wdg_two_stage.sv
module sim_wdg_two_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        warn_irq, sys_rst;
  int          total, bad;
  bit          done;

  wdg_two_stage u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .warn_irq(warn_irq), .sys_rst(sys_rst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // write in one cycle; returns at the negedge just after the write edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 warn", {31'd0, warn_irq}, 32'd0);
    check("R1 rst", {31'd0, sys_rst}, 32'd0);
    rd(2'd0, v); check("R1 ctrl", v, 32'd0);
    rd(2'd2, v); check("R1 live", v, 32'd0);
    rd(2'd3, v); check("R1 div", v, 32'd1);

    // R2 control layout, R3 divider readback
    wr(2'd0, 32'hFFFF_0A05);
    rd(2'd0, v); check("R2 ctrl readback", v, 32'h8000_0A05);
    wr(2'd0, 32'h0000_0A05);
    rd(2'd0, v); check("R2 ctrl disable", v, 32'h0000_0A05);
    wr(2'd3, 32'h0001_2345);
    rd(2'd3, v); check("R3 div readback", v, 32'h0000_2345);

    // R3 R4 R5 R6 sweep over lengths and dividers
    for (int d = 0; d < 4; d++) begin
      for (int f1 = 0; f1 < 4; f1++) begin
        for (int f2 = 0; f2 < 3; f2++) begin
          int dd, w1, w2, tw, tr, err_w, err_r;
          logic ew;
          dd = (d == 0) ? 1 : d;
          w1 = (f1 == 0) ? 1 : f1;
          w2 = (f2 == 0) ? 1 : f2;
          tw = w1 * dd; tr = (w1 + w2) * dd;
          err_w = 0; err_r = 0;
          wr(2'd3, d);
          wr(2'd0, 32'h8000_0000 | (f2 << 8) | f1);
          for (int n = 0; n <= tr + 2; n++) begin
            ew = (n >= tw) && (n < tr);
            if (warn_irq !== ew) begin
              err_w++;
              if (err_w == 1)
                $display("FAIL R5 d=%0d f1=%0d f2=%0d n=%0d actual=%0b expected=%0b", d, f1, f2, n, warn_irq, ew);
            end
            if (sys_rst !== (n == tr)) begin
              err_r++;
              if (err_r == 1)
                $display("FAIL R6 d=%0d f1=%0d f2=%0d n=%0d actual=%0b expected=%0b", d, f1, f2, n, sys_rst, (n == tr));
            end
            @(negedge clk);
          end
          total += 2;
          if (err_w != 0) bad++;
          if (err_r != 0) bad++;
          rd(2'd0, v); check("R6 enable cleared", {31'd0, v[31]}, 32'd0);
        end
      end
    end

    // R10 live counts, divider 1, lengths 5 and 3
    wr(2'd3, 32'd1);
    wr(2'd0, 32'h8000_0305);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); check("R10 live n=2", v, 32'h0000_0303);
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R10 live n=5", v, 32'h0000_0300);
    @(negedge clk);
    rd(2'd2, v); check("R10 live n=6", v, 32'h0000_0200);

    // R7 service during grace period cancels reset
    wr(2'd0, 32'h8000_0403);
    repeat (4) @(negedge clk);
    check("R7 warn before kick", {31'd0, warn_irq}, 32'd1);
    wr(2'd1, 32'd1);               // lands on edge 6, before edge 7 expiry
    check("R7 warn cleared", {31'd0, warn_irq}, 32'd0);
    rd(2'd2, v); check("R7 reloaded", v, 32'h0000_0403);
    @(negedge clk); @(negedge clk);
    check("R7 m=2 warn", {31'd0, warn_irq}, 32'd0);
    @(negedge clk);
    check("R7 m=3 warn", {31'd0, warn_irq}, 32'd1);
    repeat (3) @(negedge clk);
    check("R7 m=6 rst", {31'd0, sys_rst}, 32'd0);
    @(negedge clk);
    check("R7 m=7 rst", {31'd0, sys_rst}, 32'd1);
    @(negedge clk);

    // R8 service with bit 0 clear changes nothing, reads 0
    wr(2'd3, 32'd2);
    wr(2'd0, 32'h8000_0103);      // n=0: warn at 6, reset at 8
    wr(2'd1, 32'hFFFF_FFFE);      // returns at n=2
    rd(2'd1, v); check("R8 reads zero", v, 32'd0);
    repeat (3) @(negedge clk);    // n=5
    check("R8 n=5 warn", {31'd0, warn_irq}, 32'd0);
    @(negedge clk);
    check("R8 n=6 warn", {31'd0, warn_irq}, 32'd1);
    @(negedge clk); @(negedge clk);
    check("R8 n=8 rst", {31'd0, sys_rst}, 32'd1);
    @(negedge clk);

    // R9 disable freezes counts
    wr(2'd3, 32'd1);
    wr(2'd0, 32'h8000_0202);      // n=0
    wr(2'd0, 32'h0000_0202);      // stop at edge 2, cnt1 was 1
    rd(2'd2, v); check("R9 frozen at stop", v, 32'h0000_0201);
    repeat (10) @(negedge clk);
    rd(2'd2, v); check("R9 frozen later", v, 32'h0000_0201);
    check("R9 no warn", {31'd0, warn_irq}, 32'd0);
    check("R9 no rst", {31'd0, sys_rst}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule